// File: doc/BRIEF.md
# Per-Port Time-Code Filter

This block sits between the ports of a packet router and the logic that distributes time-codes. Each cycle it may receive one control code, together with the index of the port the code arrived on. It decides whether the code counts as a time-code and whether that code may be accepted. When it accepts a code, it raises a one-cycle valid pulse. The pulse carries the time value and a mask of the ports that should get a copy.

Acceptance depends on four things:
- a global time-code switch;
- a per-port enable vector;
- a flag-filter configuration bit;
- a global interrupt-distribution switch.

The two control flags are the top two bits of the code. While interrupt distribution is on, a code is a time-code only when both flags are zero, whatever the filter bit says. The flags of the most recently accepted time-code are held for register readback.

Top module: `tc_port_filter`

## Requirements
- R1: After reset `tc_vld` is 0, `tc_fwd_mask` is all zeros, `tc_value` is 0 and `last_flags` is 2'b00.
- R2: While `glb_tc_en` is 0, no code is accepted and `tc_vld` stays 0 whatever the other inputs are.
- R3: A code whose source port has its bit in `port_tc_en` cleared is discarded. `tc_vld` stays 0 and `last_flags` keeps its value.
- R4: The control flags are code bits 7:6. With `flag_filt` = 1 and `irq_dist_en` = 0, only flags 2'b00 are accepted. With both at 0, all four flag values are accepted.
- R5: While `irq_dist_en` = 1, only flags 2'b00 are accepted, whether `flag_filt` is 0 or 1.
- R6: On acceptance, `tc_fwd_mask` equals `port_tc_en` with the source port's bit cleared (bit i stands for port i).
- R7: A code presented with `code_vld` at clock edge k yields `tc_vld` = 1 right after edge k. `tc_value` then equals code bits 5:0. `tc_vld` returns to 0 after edge k+1 unless another code is accepted there.
- R8: `last_flags` takes bits 7:6 of each accepted code at the same edge that raises `tc_vld`. It never changes at any other time.
- R9: A `code_port` value of `NUM_PORTS` or more is discarded.
- R10: Whenever `tc_vld` is 0, `tc_value` and `tc_fwd_mask` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_vld | input | 1 | A control code is presented this cycle |
| code_port | input | IDX_W | Index of the port the code arrived on |
| code_data | input | CODE_W | The code; flags in the top two bits, time value below |
| glb_tc_en | input | 1 | Global time-code enable |
| port_tc_en | input | NUM_PORTS | Per-port time-code enable |
| flag_filt | input | 1 | 1: accept only flags 00; 0: ignore the flags |
| irq_dist_en | input | 1 | Interrupt distribution on; forces flags-00-only |
| tc_vld | output | 1 | One-cycle pulse for an accepted time-code |
| tc_value | output | CODE_W-2 | Time value of the accepted code |
| tc_fwd_mask | output | NUM_PORTS | Ports that should receive the time-code |
| last_flags | output | 2 | Flags of the last accepted time-code |

## Verification
The bench builds the block with `NUM_PORTS` = 5, so the 3-bit port index reaches the out-of-range values 5 to 7 that R9 covers. It sweeps every index value against all four flag values and all combinations of the three configuration bits. It repeats the sweep under three port-enable patterns, so each port is seen both enabled and disabled as a source and as a destination. The expected results come from arithmetic on the inputs, and a running copy of the last accepted flags is kept in the bench.

// File: rtl/tc_filter_pkg.sv
package tc_filter_pkg;
   localparam int unsigned FLAG_W = 2;

   typedef enum logic [1:0] {
      FLAGS_TIME  = 2'b00,
      FLAGS_RSV1  = 2'b01,
      FLAGS_IRQ   = 2'b10,
      FLAGS_RSV3  = 2'b11
   } flag_code_e;

   function automatic logic flags_ok(input logic [FLAG_W-1:0] flags,
                                     input logic strict);
      return strict ? (flags == FLAGS_TIME) : 1'b1;
   endfunction
endpackage

// File: rtl/tc_qualify.sv
module tc_qualify
   import tc_filter_pkg::*;
#(
   parameter int unsigned CODE_W = 8,
   localparam int unsigned VAL_W = CODE_W - FLAG_W
) (
   input  logic [CODE_W-1:0] code,
   input  logic              flag_filt,
   input  logic              irq_dist_en,
   output logic              is_time,
   output logic [FLAG_W-1:0] flags,
   output logic [VAL_W-1:0]  value
);
   logic strict;

   assign flags  = code[CODE_W-1 -: FLAG_W];
   assign value  = code[VAL_W-1:0];
   assign strict = flag_filt | irq_dist_en;

   always_comb begin
      is_time = flags_ok(flags, strict);
   end
endmodule

// File: rtl/tc_port_decode.sv
module tc_port_decode #(
   parameter int unsigned NUM_PORTS = 8,
   localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [IDX_W-1:0]     idx,
   input  logic [NUM_PORTS-1:0] port_en,
   output logic [NUM_PORTS-1:0] hit,
   output logic                 in_range,
   output logic                 src_en
);
   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_hit
      assign hit[i] = (idx == IDX_W'(i));
   end

   assign in_range = |hit;
   assign src_en   = |(hit & port_en);
endmodule

// File: rtl/tc_port_filter.sv
module tc_port_filter
   import tc_filter_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 8,
   parameter int unsigned CODE_W    = 8,
   localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int unsigned VAL_W = CODE_W - FLAG_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 code_vld,
   input  logic [IDX_W-1:0]     code_port,
   input  logic [CODE_W-1:0]    code_data,
   input  logic                 glb_tc_en,
   input  logic [NUM_PORTS-1:0] port_tc_en,
   input  logic                 flag_filt,
   input  logic                 irq_dist_en,
   output logic                 tc_vld,
   output logic [VAL_W-1:0]     tc_value,
   output logic [NUM_PORTS-1:0] tc_fwd_mask,
   output logic [FLAG_W-1:0]    last_flags
);
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("tc_port_filter: NUM_PORTS must be at least 2");
   end
   if (CODE_W <= FLAG_W) begin : g_bad_width
      $error("tc_port_filter: CODE_W must exceed the flag width");
   end

   logic                 is_time;
   logic [FLAG_W-1:0]    flags;
   logic [VAL_W-1:0]     value;
   logic [NUM_PORTS-1:0] src_hit;
   logic                 in_range;
   logic                 src_en;
   logic                 accept;
   logic [NUM_PORTS-1:0] fwd_next;

   tc_qualify #(.CODE_W(CODE_W)) u_qual (
      .code        (code_data),
      .flag_filt   (flag_filt),
      .irq_dist_en (irq_dist_en),
      .is_time     (is_time),
      .flags       (flags),
      .value       (value)
   );

   tc_port_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
      .idx      (code_port),
      .port_en  (port_tc_en),
      .hit      (src_hit),
      .in_range (in_range),
      .src_en   (src_en)
   );

   assign accept   = code_vld & glb_tc_en & in_range & src_en & is_time;
   assign fwd_next = port_tc_en & ~src_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_vld      <= 1'b0;
         tc_value    <= '0;
         tc_fwd_mask <= '0;
         last_flags  <= FLAGS_TIME;
      end else begin
         tc_vld      <= accept;
         tc_value    <= accept ? value : '0;
         tc_fwd_mask <= accept ? fwd_next : '0;
         if (accept) begin
            last_flags <= flags;
         end
      end
   end
endmodule

// File: rtl/tc_port_filter_chk.sv
module tc_port_filter_chk #(
   parameter int unsigned NUM_PORTS = 8,
   parameter int unsigned CODE_W    = 8,
   localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int unsigned VAL_W = CODE_W - 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 code_vld,
   input logic [IDX_W-1:0]     code_port,
   input logic [CODE_W-1:0]    code_data,
   input logic                 glb_tc_en,
   input logic [NUM_PORTS-1:0] port_tc_en,
   input logic                 flag_filt,
   input logic                 irq_dist_en,
   input logic                 tc_vld,
   input logic [VAL_W-1:0]     tc_value,
   input logic [NUM_PORTS-1:0] tc_fwd_mask,
   input logic [1:0]           last_flags
);
   a_r2_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      tc_vld |-> $past(glb_tc_en));

   a_r3_src_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      tc_vld |-> (($past(port_tc_en) >> $past(code_port)) & 1) != 0);

   a_r4_filter_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_vld && $past(flag_filt)) |-> last_flags == 2'b00);

   a_r5_irq_forces_00: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_vld && $past(irq_dist_en)) |-> last_flags == 2'b00);

   a_r6_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
      tc_vld |-> ((tc_fwd_mask & ~$past(port_tc_en)) == '0));

   a_r7_value: assert property (@(posedge clk) disable iff (!rst_n)
      tc_vld |-> ($past(code_vld) && tc_value == $past(code_data[VAL_W-1:0])));

   a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(last_flags) |-> tc_vld);

   a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
      tc_vld |-> $past(code_port) < IDX_W'(NUM_PORTS));

   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !tc_vld |-> (tc_value == '0 && tc_fwd_mask == '0));
endmodule

bind tc_port_filter tc_port_filter_chk #(.NUM_PORTS(NUM_PORTS), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_tc_port_filter.sv
`timescale 1ns/1ps
module tb_tc_port_filter;
   localparam int unsigned NP = 5;
   localparam int unsigned IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          code_vld = 1'b0;
   logic [IW-1:0] code_port = '0;
   logic [7:0]    code_data = '0;
   logic          glb_tc_en = 1'b0;
   logic [NP-1:0] port_tc_en = '0;
   logic          flag_filt = 1'b0;
   logic          irq_dist_en = 1'b0;
   logic          tc_vld;
   logic [5:0]    tc_value;
   logic [NP-1:0] tc_fwd_mask;
   logic [1:0]    last_flags;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   logic [1:0]  exp_last = 2'b00;
   bit          done = 0;

   always #2.5 clk = ~clk;

   tc_port_filter #(.NUM_PORTS(NP), .CODE_W(8)) dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply(input int port, input int flags, input int val,
                        input bit g, input logic [NP-1:0] en, input bit f, input bit irq);
      bit acc;
      bit strict;
      logic [NP-1:0] exp_mask;
      @(negedge clk);
      code_vld = 1'b1; code_port = IW'(port);
      code_data = {2'(flags), 6'(val)};
      glb_tc_en = g; port_tc_en = en; flag_filt = f; irq_dist_en = irq;
      strict = f | irq;
      acc = g && (port < NP) && en[port % NP] && (!strict || flags == 0);
      exp_mask = acc ? (en & ~(NP'(1) << port)) : '0;
      @(posedge clk); #1;
      // R2 R3 R4 R5 R9: acceptance decision
      check(g ? (port >= NP ? "R9" : (!en[port % NP] ? "R3" : (irq ? "R5" : "R4"))) : "R2",
            32'(tc_vld), 32'(acc));
      check("R7", 32'(tc_value), acc ? 32'(val) : 32'd0);
      check(acc ? "R6" : "R10", 32'(tc_fwd_mask), 32'(exp_mask));
      if (acc) exp_last = 2'(flags);
      check("R8", 32'(last_flags), 32'(exp_last));
      @(negedge clk);
      code_vld = 1'b0;
      @(posedge clk); #1;
      check("R7", 32'(tc_vld), 32'd0);
      check("R10", 32'(tc_fwd_mask), 32'd0);
      check("R8", 32'(last_flags), 32'(exp_last));
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [NP-1:0] pats [3];
      pats[0] = 5'b10110; pats[1] = 5'b11111; pats[2] = 5'b01001;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1", 32'(tc_vld), 32'd0);
      check("R1", 32'(tc_fwd_mask), 32'd0);
      check("R1", 32'(tc_value), 32'd0);
      check("R1", 32'(last_flags), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      for (int p = 0; p < 3; p++)
         for (int port = 0; port < 8; port++)
            for (int fl = 0; fl < 4; fl++)
               for (int cfg = 0; cfg < 8; cfg++)
                  apply(port, fl, (port * 13 + fl * 7 + cfg * 5 + p) % 64,
                        cfg[0], pats[p], cfg[1], cfg[2]);
      // R8: a discarded code with nonzero flags leaves last_flags untouched
      apply(0, 3, 21, 1'b1, 5'b11111, 1'b0, 1'b0);
      apply(1, 2, 9, 1'b1, 5'b11101, 1'b0, 1'b0);
      check("R8", 32'(last_flags), 32'd3);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule